// File: doc/BRIEF.md
# Serial Register-Access Slave Port

This block lets an external serial master read and write a bank of 128 eight-bit registers. Each transaction begins when the active-low select line falls. The first byte is a command: a direction flag in its top bit (1 = read, 0 = write) and a 7-bit register address below it. Data bytes follow, eight serial clocks each, for as long as select stays low. The register address steps up by one after every data byte and rolls over from 0x7F to 0x00.

The serial clock idles low. The slave samples incoming bits on the rising edge and changes outgoing bits on the falling edge. All pins are brought into the system clock domain through synchronisers, so the serial clock must run well below the system clock. The port starts in four-wire mode, with a separate data-out pin. Bit 0 of control register 0x00 switches it to three-wire mode, where the incoming data line also carries read data back, driven through an output enable. Writing 0x00 with bit 6 set performs a soft reset: every register clears and the port returns to four-wire mode.

The bank can also be read in parallel by on-chip logic through a separate address/data port.

Top module: `spi_reg_slave`

## Requirements
- R1: After the synchronous reset, every register reads 0, `three_wire` is 0, and both `sdo_oe` and `sdi_oe` are 0.
- R2: A transaction whose command bit 7 is 0 writes the byte carried on serial clocks 9 to 16 (MSB first) into the register named by command bits 6:0.
- R3: A transaction whose command bit 7 is 1 returns the addressed register MSB first. Each bit is valid before one of rising clocks 9 to 16 and holds steady while the serial clock is high.
- R4: In a burst write, each additional 8-clock byte goes to the previous address plus one, wrapping from 0x7F to 0x00.
- R5: In a burst read, each additional byte comes from the previous address plus one, with the same wrap.
- R6: A data byte cut short by select rising leaves the register unchanged, and the next transaction restarts its bit count from the command bit.
- R7: In four-wire mode, `sdo_oe` is 1 while select is low and 0 while it is high, and `sdi_oe` stays 0.
- R8: When register 0x00 bit 0 is 1 (three-wire mode), read data appears on `sdi_out`. `sdi_oe` is 1 only in the data phase of a read, and `sdo_oe` stays 0.
- R9: Writing register 0x00 with bit 6 set clears all registers, which returns the port to four-wire mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock, idle low |
| sdi | input | 1 | Serial data in; in three-wire mode the shared data line |
| sdo | output | 1 | Four-wire serial data out |
| sdo_oe | output | 1 | Output enable for `sdo` |
| sdi_out | output | 1 | Read data driven onto the shared line in three-wire mode |
| sdi_oe | output | 1 | Output enable for the shared line |
| host_addr | input | 7 | Parallel read address into the register bank |
| host_rdata | output | 8 | Parallel read data |
| three_wire | output | 1 | Current wire mode, 1 = three-wire |

## Verification
A burst write that crosses the top of the address space is the case where two functions meet. In one system cycle, the write commit of the byte aimed at 0x7F coincides with the address rolling over to 0x00, the control register. The bench provokes this with a four-byte write that starts at 0x7E. It then reads every target back through the parallel port, and reads the same span again through a serial burst read. The third byte is chosen with bits 0 and 6 clear. A mis-wrapped or mistimed commit therefore shows up as a wrong value at 0x7F or 0x00, or as a spurious mode change.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;

    parameter int ADDR_W    = 7;
    parameter int DATA_W    = 8;
    parameter int NREGS     = 1 << ADDR_W;
    parameter int BIT_CNT_W = $clog2(DATA_W);
    parameter int CTRL_ADDR = 0;
    parameter int MODE_BIT  = 0;
    parameter int SRST_BIT  = 6;

    typedef enum logic {
        PH_CMD  = 1'b0,
        PH_DATA = 1'b1
    } phase_e;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    typedef struct packed {
        logic sel;
        logic rise;
        logic fall;
        logic din;
    } pin_ev_t;

    function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
        return a + 1'b1;
    endfunction

    function automatic logic is_last_bit(input logic [BIT_CNT_W-1:0] c);
        return c == BIT_CNT_W'(DATA_W - 1);
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync
    import spi_regs_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    cs_n,
    input  logic    sclk,
    input  logic    sdi,
    output pin_ev_t ev
);
    localparam int NPINS = 3;
    localparam logic [NPINS-1:0] RST_VAL = 3'b001;

    logic [NPINS-1:0] raw;
    logic [NPINS-1:0] synced;
    logic             sclk_d;

    assign raw = {sdi, sclk, cs_n};

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= {STAGES{RST_VAL[p]}};
            else     chain <= {chain[STAGES-2:0], raw[p]};
        end
        assign synced[p] = chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) sclk_d <= 1'b0;
        else     sclk_d <= synced[1];
    end

    always_comb begin
        ev.sel  = ~synced[0];
        ev.rise = ~synced[0] &  synced[1] & ~sclk_d;
        ev.fall = ~synced[0] & ~synced[1] &  sclk_d;
        ev.din  = synced[2];
    end
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
    import spi_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  pin_ev_t           ev,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              three_wire,
    output logic [ADDR_W-1:0] rd_addr,
    output wr_req_t           wr,
    output logic              tx_bit,
    output logic              drive_4w,
    output logic              drive_3w
);
    logic [BIT_CNT_W-1:0] bit_cnt;
    phase_e               phase;
    logic                 is_rd;
    logic [ADDR_W-1:0]    addr;
    logic [DATA_W-2:0]    rx;
    logic [DATA_W-1:0]    tx;
    logic                 rd_active;
    logic [DATA_W-1:0]    rx_byte;

    assign rx_byte = {rx, ev.din};

    always_ff @(posedge clk) begin
        wr.we <= 1'b0;
        if (rst || !ev.sel) begin
            bit_cnt   <= '0;
            phase     <= PH_CMD;
            is_rd     <= 1'b0;
            rd_active <= 1'b0;
            if (rst) begin
                addr    <= '0;
                rx      <= '0;
                tx      <= '0;
                wr.addr <= '0;
                wr.data <= '0;
            end
        end else begin
            if (ev.rise) begin
                rx      <= rx_byte[DATA_W-2:0];
                bit_cnt <= bit_cnt + 1'b1;
                if (is_last_bit(bit_cnt)) begin
                    if (phase == PH_CMD) begin
                        is_rd <= rx_byte[DATA_W-1];
                        addr  <= rx_byte[ADDR_W-1:0];
                        phase <= PH_DATA;
                    end else begin
                        if (!is_rd) begin
                            wr.we   <= 1'b1;
                            wr.addr <= addr;
                            wr.data <= rx_byte;
                        end
                        addr <= step_addr(addr);
                    end
                end
            end
            if (ev.fall && phase == PH_DATA && is_rd) begin
                if (bit_cnt == '0) begin
                    tx        <= rd_data;
                    rd_active <= 1'b1;
                end else begin
                    tx <= {tx[DATA_W-2:0], 1'b0};
                end
            end
        end
    end

    assign rd_addr  = addr;
    assign tx_bit   = tx[DATA_W-1];
    assign drive_4w = ev.sel & ~three_wire;
    assign drive_3w = ev.sel & three_wire & rd_active;
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
    import spi_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           wr,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [ADDR_W-1:0] host_addr,
    output logic [DATA_W-1:0] host_rdata,
    output logic              three_wire
);
    logic [DATA_W-1:0] regs [NREGS];
    logic              soft_rst;

    assign soft_rst = wr.we && (wr.addr == ADDR_W'(CTRL_ADDR)) && wr.data[SRST_BIT];

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (wr.we) begin
            regs[wr.addr] <= wr.data;
        end
    end

    assign rd_data    = regs[rd_addr];
    assign host_rdata = regs[host_addr];
    assign three_wire = regs[CTRL_ADDR][MODE_BIT];
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
    import spi_regs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              sdi_out,
    output logic              sdi_oe,
    input  logic [ADDR_W-1:0] host_addr,
    output logic [DATA_W-1:0] host_rdata,
    output logic              three_wire
);
    pin_ev_t           ev;
    wr_req_t           wr_q;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              tx_bit;
    logic              drive_4w;
    logic              drive_3w;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .cs_n (cs_n),
        .sclk (sclk),
        .sdi  (sdi),
        .ev   (ev)
    );

    spi_frame_engine u_eng (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .rd_data    (rd_data),
        .three_wire (three_wire),
        .rd_addr    (rd_addr),
        .wr         (wr_q),
        .tx_bit     (tx_bit),
        .drive_4w   (drive_4w),
        .drive_3w   (drive_3w)
    );

    spi_reg_bank u_bank (
        .clk        (clk),
        .rst        (rst),
        .wr         (wr_q),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .host_addr  (host_addr),
        .host_rdata (host_rdata),
        .three_wire (three_wire)
    );

    assign sdo     = tx_bit;
    assign sdo_oe  = drive_4w;
    assign sdi_out = tx_bit;
    assign sdi_oe  = drive_3w;
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk
    import spi_regs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              sdo_oe,
    input logic              sdi_oe,
    input logic              three_wire,
    input logic              wr_we,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data
);
    // R1
    reset_mode_chk: assert property (@(posedge clk) rst |=> !three_wire && !sdo_oe && !sdi_oe);

    // R7
    desel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> (!sdo_oe && !sdi_oe));

    // R7
    four_wire_no_shared_chk: assert property (@(posedge clk) disable iff (rst)
        !three_wire |-> !sdi_oe);

    // R8
    three_wire_no_sdo_chk: assert property (@(posedge clk) disable iff (rst)
        three_wire |-> !sdo_oe);

    // R9
    soft_reset_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_we && wr_addr == ADDR_W'(CTRL_ADDR) && wr_data[SRST_BIT]) |=> !three_wire);
endmodule

bind spi_reg_slave spi_reg_slave_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cs_n),
    .sdo_oe     (sdo_oe),
    .sdi_oe     (sdi_oe),
    .three_wire (three_wire),
    .wr_we      (wr_q.we),
    .wr_addr    (wr_q.addr),
    .wr_data    (wr_q.data)
);

// File: tb/sim_spi_reg_slave.sv
module sim_spi_reg_slave;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       drv_sdi = 1'b0;
    logic       sdi;
    logic       sdo, sdo_oe, sdi_out, sdi_oe, three_wire;
    logic [6:0] host_addr = '0;
    logic [7:0] host_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] txb [8];
    logic [7:0] rxb [8];
    bit stable_ok, oe_ok;

    localparam int HALF = 8;

    always #4 clk = ~clk;

    assign sdi = sdi_oe ? sdi_out : drv_sdi;

    spi_reg_slave u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .sdi_out(sdi_out), .sdi_oe(sdi_oe),
        .host_addr(host_addr), .host_rdata(host_rdata), .three_wire(three_wire)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic host_peek(input logic [6:0] a, output logic [7:0] v);
        host_addr = a;
        tick(1);
        v = host_rdata;
    endtask

    // One serial transaction. lastbits < 8 cuts the final data byte short.
    task automatic spi_xfer(input bit rd, input logic [6:0] a, input int nbytes,
                            input bit tw, input int lastbits);
        logic [7:0] cmd;
        bit         smp, pre;
        cmd = {rd, a};
        stable_ok = 1'b1;
        oe_ok = 1'b1;
        cs_n = 1'b0;
        tick(HALF);
        for (int i = 7; i >= 0; i--) begin
            drv_sdi = cmd[i];
            tick(HALF);
            if (tw && sdi_oe) oe_ok = 1'b0;
            if (!tw && !sdo_oe) oe_ok = 1'b0;
            sclk = 1'b1;
            tick(HALF);
            sclk = 1'b0;
        end
        for (int b = 0; b < nbytes; b++) begin
            int nb;
            nb = (b == nbytes - 1) ? lastbits : 8;
            rxb[b] = '0;
            for (int i = 7; i >= 8 - nb; i--) begin
                if (!rd) drv_sdi = txb[b][i];
                tick(HALF);
                pre = tw ? sdi : sdo;
                if (rd && tw && !sdi_oe) oe_ok = 1'b0;
                if (tw && sdo_oe) oe_ok = 1'b0;
                if (!tw && (!sdo_oe || sdi_oe)) oe_ok = 1'b0;
                rxb[b][i] = pre;
                sclk = 1'b1;
                tick(HALF - 1);
                smp = tw ? sdi : sdo;
                if (rd && smp != pre) stable_ok = 1'b0;
                tick(1);
                sclk = 1'b0;
            end
        end
        tick(HALF);
        cs_n = 1'b1;
        tick(2 * HALF);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        host_peek(7'h00, v); chk(v == 8'h00, "R1 reg 0x00", v, 0);
        host_peek(7'h7F, v); chk(v == 8'h00, "R1 reg 0x7F", v, 0);
        chk(three_wire == 1'b0, "R1 three_wire", three_wire, 0);
        chk(!sdo_oe && !sdi_oe, "R1 enables", {sdo_oe, sdi_oe}, 0);
    endtask

    task automatic t_single_write();
        logic [7:0] v;
        txb[0] = 8'h5A;
        spi_xfer(1'b0, 7'h12, 1, 1'b0, 8);
        host_peek(7'h12, v); chk(v == 8'h5A, "R2 single write", v, 8'h5A);
        chk(oe_ok, "R7 sdo_oe low-select window", oe_ok, 1);
        chk(!sdo_oe, "R7 sdo_oe after select high", sdo_oe, 0);
    endtask

    task automatic t_single_read();
        spi_xfer(1'b1, 7'h12, 1, 1'b0, 8);
        chk(rxb[0] == 8'h5A, "R3 single read", rxb[0], 8'h5A);
        chk(stable_ok, "R3 bit stable while sclk high", stable_ok, 1);
        chk(oe_ok, "R7 four-wire enables during read", oe_ok, 1);
    endtask

    task automatic t_burst_wrap();
        logic [7:0] v;
        txb[0] = 8'hA1; txb[1] = 8'hB2; txb[2] = 8'h80; txb[3] = 8'h77;
        spi_xfer(1'b0, 7'h7E, 4, 1'b0, 8);
        host_peek(7'h7E, v); chk(v == 8'hA1, "R4 burst 0x7E", v, 8'hA1);
        host_peek(7'h7F, v); chk(v == 8'hB2, "R4 burst 0x7F", v, 8'hB2);
        host_peek(7'h00, v); chk(v == 8'h80, "R4 burst wrap 0x00", v, 8'h80);
        host_peek(7'h01, v); chk(v == 8'h77, "R4 burst 0x01", v, 8'h77);
        chk(three_wire == 1'b0, "R4 wrap write keeps mode", three_wire, 0);
        spi_xfer(1'b1, 7'h7F, 3, 1'b0, 8);
        chk(rxb[0] == 8'hB2, "R5 burst read 0x7F", rxb[0], 8'hB2);
        chk(rxb[1] == 8'h80, "R5 burst read wrap 0x00", rxb[1], 8'h80);
        chk(rxb[2] == 8'h77, "R5 burst read 0x01", rxb[2], 8'h77);
    endtask

    task automatic t_partial();
        logic [7:0] v;
        txb[0] = 8'hFF;
        spi_xfer(1'b0, 7'h12, 1, 1'b0, 5);
        host_peek(7'h12, v); chk(v == 8'h5A, "R6 partial byte dropped", v, 8'h5A);
        txb[0] = 8'h3C;
        spi_xfer(1'b0, 7'h13, 1, 1'b0, 8);
        host_peek(7'h13, v); chk(v == 8'h3C, "R6 next frame restarts", v, 8'h3C);
        host_peek(7'h12, v); chk(v == 8'h5A, "R6 neighbour untouched", v, 8'h5A);
    endtask

    task automatic t_three_wire();
        logic [7:0] v;
        txb[0] = 8'h01;
        spi_xfer(1'b0, 7'h00, 1, 1'b0, 8);
        chk(three_wire == 1'b1, "R8 mode bit selects three-wire", three_wire, 1);
        spi_xfer(1'b1, 7'h12, 2, 1'b1, 8);
        chk(rxb[0] == 8'h5A, "R8 three-wire read 0x12", rxb[0], 8'h5A);
        chk(rxb[1] == 8'h3C, "R8 three-wire burst 0x13", rxb[1], 8'h3C);
        chk(oe_ok, "R8 shared-line enable only in read data", oe_ok, 1);
        chk(!sdi_oe && !sdo_oe, "R8 released after select high", {sdo_oe, sdi_oe}, 0);
        txb[0] = 8'h99;
        spi_xfer(1'b0, 7'h14, 1, 1'b1, 8);
        host_peek(7'h14, v); chk(v == 8'h99, "R8 three-wire write", v, 8'h99);
        chk(oe_ok, "R8 no drive during write", oe_ok, 1);
    endtask

    task automatic t_soft_reset();
        logic [7:0] v;
        txb[0] = 8'h41;
        spi_xfer(1'b0, 7'h00, 1, 1'b1, 8);
        chk(three_wire == 1'b0, "R9 soft reset back to four-wire", three_wire, 0);
        host_peek(7'h12, v); chk(v == 8'h00, "R9 reg 0x12 cleared", v, 0);
        host_peek(7'h00, v); chk(v == 8'h00, "R9 reg 0x00 cleared", v, 0);
        spi_xfer(1'b1, 7'h7E, 1, 1'b0, 8);
        chk(rxb[0] == 8'h00, "R9 serial read after soft reset", rxb[0], 0);
    endtask

    initial begin
        tick(5);
        rst = 1'b0;
        tick(4);
        t_reset();
        t_single_write();
        t_single_read();
        t_burst_wrap();
        t_partial();
        t_three_wire();
        t_soft_reset();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(negedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule